// File: doc/BRIEF.md
# Vectored Fast/Normal Interrupt Controller

This block gathers interrupt requests from up to 26 on-chip peripherals into a sticky pending register. A mask register screens the requests. A per-source mode bit steers each unmasked pending request onto one of two active-low processor lines: a fast line, or a normal line. Software reaches the block through a simple word-wide register port that has separate read and write strobes. Software can clear pending bits by writing 1 to them. It can also force a pattern into the pending register through a test register.

A vector offset register gives a quick dispatch value. It holds the position of the lowest-numbered pending source multiplied by four. When nothing is pending it holds the code 0x54. Register addresses are word indices: 0 mode, 1 pending, 2 mask, 3 test, 4 fast-offset store, 5 vector offset. Any other address in the range is unmapped.

Top module: `intc_vec_top`

## Requirements
- R1: While reset is high and on the first cycle after it falls, the state is as follows. Mask holds all 26 source bits set. Mode, pending and test are zero. The fast-offset store (address 4) holds 0x54. Both `fiq_n` and `irq_n` are high.
- R2: A request bit that is high at a rising clock edge sets its pending bit (bit i = source i, read at address 1). The bit stays set until software clears it.
- R3: A write to address 1 clears each pending bit whose data bit is 1. Pending bits written as 0 keep their value.
- R4: A request and a clear that hit the same bit at the same edge leave the bit set.
- R5: The active set is pending AND NOT mask. `fiq_n` is low exactly when some active bit has mode 1. `irq_n` is low exactly when some active bit has mode 0. Both lines show the state one clock after that state is updated.
- R6: A read of address 5 returns the index of the lowest set pending bit times four, ignoring the mask. It returns 0x54 when no bit is pending. Writes to address 5 have no effect.
- R7: A write to address 3 loads bits 25:0 of the data into both the test register (read at address 3) and the pending register. Requests at the same edge are ORed on top.
- R8: The mode register (address 0) and the mask register (address 2) read back what was written, limited to bits 25:0. Bits 31:26 read as 0. Address 4 stores and returns all 32 bits.
- R9: A read of any address from 6 to 15 returns 0xFFFF_FFFF.
- R10: `rdata` is updated at the edge that samples `rd_en`, with the value from before that edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 26 | Peripheral requests, one bit per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| fiq_n | output | 1 | Fast interrupt line, active low |
| irq_n | output | 1 | Normal interrupt line, active low |

## Verification
The assertions check several things on every cycle:
- a request is always latched into pending;
- no pending bit rises without a request or a test load;
- a line that goes low always traces back to an active request with the matching mode;
- the vector encoder always points at the lowest set bit;
- an unmapped read returns all ones.

Some behaviour only the bench's scenarios can show. These are the exact readback values of every register, write-one-to-clear against a concurrent request, the test-load path, and the one-cycle lag of the lines. The bench shows them by comparing every read and every line value against a reference model, under random traffic and directed corner cases.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] NONE_CODE = 32'h0000_0054;

  typedef enum logic [3:0] {
    SEL_MODE  = 4'd0,
    SEL_PEND  = 4'd1,
    SEL_MASK  = 4'd2,
    SEL_TEST  = 4'd3,
    SEL_FAST  = 4'd4,
    SEL_VEC   = 4'd5
  } reg_sel_e;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NSRC = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            clr_en,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            load_en,
  input  logic [NSRC-1:0] load_val,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] base;
  logic [NSRC-1:0] pend_nx;

  always_comb begin
    base = pend;
    if (load_en)
      base = load_val;
    else if (clr_en)
      base = pend & ~clr_bits;
    pend_nx = base | req;   // set wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_nx;
  end

  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (|$past(req)) |-> ((pend & $past(req)) == $past(req))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !$past(load_en) |-> ((pend & ~$past(pend) & ~$past(req)) == '0)); // R2
endmodule

// File: rtl/intc_first_set.sv
module intc_first_set #(
  parameter int NSRC = 26,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_line_drive.sv
module intc_line_drive #(
  parameter int NSRC = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] mode,
  output logic            fiq_n,
  output logic            irq_n
);
  logic [NSRC-1:0] active;
  assign active = pend & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_n <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      fiq_n <= ~|(active & mode);
      irq_n <= ~|(active & ~mode);
    end
  end

  AST_FAST_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !fiq_n |-> $past(|(pend & ~mask & mode))); // R5

  AST_NORM_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|(pend & ~mask & ~mode))); // R5

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(pend & ~mask) == '0) |-> (fiq_n && irq_n)); // R5
endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
  import intc_pkg::*;
#(
  parameter int NSRC   = 26,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              fiq_n,
  output logic              irq_n
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int PAD_W = DATA_W - NSRC;
  localparam int OFS_PAD = DATA_W - IDX_W - 2;

  logic [NSRC-1:0]   mode_q, mask_q, test_q, pend;
  logic [DATA_W-1:0] fast_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] vec_ofs;
  logic              enc_found;
  logic [IDX_W-1:0]  enc_idx;
  logic              hit_mode, hit_pend, hit_mask, hit_test, hit_fast, hit_vec;
  logic              unmapped;

  assign hit_mode = (addr == ADDR_W'(SEL_MODE));
  assign hit_pend = (addr == ADDR_W'(SEL_PEND));
  assign hit_mask = (addr == ADDR_W'(SEL_MASK));
  assign hit_test = (addr == ADDR_W'(SEL_TEST));
  assign hit_fast = (addr == ADDR_W'(SEL_FAST));
  assign hit_vec  = (addr == ADDR_W'(SEL_VEC));
  assign unmapped = ~(hit_mode | hit_pend | hit_mask | hit_test | hit_fast | hit_vec);

  intc_pending #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .req      (irq_req),
    .clr_en   (wr_en & hit_pend),
    .clr_bits (wdata[NSRC-1:0]),
    .load_en  (wr_en & hit_test),
    .load_val (wdata[NSRC-1:0]),
    .pend     (pend)
  );

  intc_first_set #(.NSRC(NSRC)) u_enc (
    .vec   (pend),
    .found (enc_found),
    .idx   (enc_idx)
  );

  intc_line_drive #(.NSRC(NSRC)) u_lines (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .mask  (mask_q),
    .mode  (mode_q),
    .fiq_n (fiq_n),
    .irq_n (irq_n)
  );

  assign vec_ofs = enc_found ? {{OFS_PAD{1'b0}}, enc_idx, 2'b00} : NONE_CODE;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      mask_q <= '1;
      test_q <= '0;
      fast_q <= NONE_CODE;
    end else if (wr_en) begin
      if (hit_mode) mode_q <= wdata[NSRC-1:0];
      if (hit_mask) mask_q <= wdata[NSRC-1:0];
      if (hit_test) test_q <= wdata[NSRC-1:0];
      if (hit_fast) fast_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '1;
    if (hit_mode) rd_mux = {{PAD_W{1'b0}}, mode_q};
    if (hit_pend) rd_mux = {{PAD_W{1'b0}}, pend};
    if (hit_mask) rd_mux = {{PAD_W{1'b0}}, mask_q};
    if (hit_test) rd_mux = {{PAD_W{1'b0}}, test_q};
    if (hit_fast) rd_mux = fast_q;
    if (hit_vec)  rd_mux = vec_ofs;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_ENC_LOWEST: assert property (@(posedge clk) disable iff (rst)
    enc_found |-> (pend[enc_idx] && ((pend & ((NSRC'(1) << enc_idx) - NSRC'(1))) == '0))); // R6

  AST_ENC_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !enc_found |-> (pend == '0)); // R6

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |=> (rdata == '1)); // R9

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((mask_q == '1) && (mode_q == '0) && (pend == '0) && fiq_n && irq_n)); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rdata)); // R10
endmodule

// File: tb/tb_intc_vec_top.sv
module tb_intc_vec_top;
  localparam int NSRC = 26;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] irq_req;
  logic            wr_en, rd_en;
  logic [3:0]      addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic            fiq_n, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [NSRC-1:0] m_pend, m_mask, m_mode, m_test;
  logic [31:0]     m_fast;
  logic [31:0]     prev_rdata;

  always #4 clk = ~clk;

  intc_vec_top dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_model(input logic [NSRC-1:0] p);
    for (int i = 0; i < NSRC; i++)
      if (p[i]) return 32'(i) << 2;
    return 32'h54;
  endfunction

  function automatic logic [31:0] read_model(input logic [3:0] a);
    case (a)
      4'd0: return {6'b0, m_mode};
      4'd1: return {6'b0, m_pend};
      4'd2: return {6'b0, m_mask};
      4'd3: return {6'b0, m_test};
      4'd4: return m_fast;
      4'd5: return vec_model(m_pend);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    case (a)
      4'd0, 4'd2: return "R8";
      4'd1: return "R2";
      4'd3: return "R7";
      4'd4: return "R8";
      4'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_pend = '0; m_mask = '1; m_mode = '0; m_test = '0; m_fast = 32'h54;
  endtask

  // One bus cycle: drive at negedge, compare after the edge.
  task automatic cyc(input bit wr, input bit rd, input logic [3:0] a,
                     input logic [31:0] d, input logic [NSRC-1:0] rq);
    logic exp_f, exp_i;
    logic [31:0] exp_rd;
    logic [NSRC-1:0] np;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d; irq_req = rq;
    prev_rdata = rdata;
    exp_f  = ~|(m_pend & ~m_mask & m_mode);
    exp_i  = ~|(m_pend & ~m_mask & ~m_mode);
    exp_rd = read_model(a);
    np = m_pend;
    if (wr && a == 4'd1) np = np & ~d[NSRC-1:0];
    if (wr && a == 4'd3) begin np = d[NSRC-1:0]; m_test = d[NSRC-1:0]; end
    if (wr && a == 4'd0) m_mode = d[NSRC-1:0];
    if (wr && a == 4'd2) m_mask = d[NSRC-1:0];
    if (wr && a == 4'd4) m_fast = d;
    m_pend = np | rq;
    @(posedge clk); #1;
    chk("R5 fiq_n", {31'b0, fiq_n}, {31'b0, exp_f});
    chk("R5 irq_n", {31'b0, irq_n}, {31'b0, exp_i});
    if (rd) chk(read_tag(a), rdata, exp_rd);
    else    chk("R10 hold", rdata, prev_rdata);
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag, input logic [31:0] exp);
    cyc(0, 1, a, 0, '0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; irq_req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fiq_n in reset", {31'b0, fiq_n}, 32'd1);
    chk("R1 irq_n in reset", {31'b0, irq_n}, 32'd1);
    rst = 1'b0;
    model_reset();
    // R1 reset readback
    rd_chk(4'd2, "R1 mask", 32'h03FF_FFFF);
    rd_chk(4'd0, "R1 mode", 32'h0);
    rd_chk(4'd1, "R1 pend", 32'h0);
    rd_chk(4'd4, "R1 fast", 32'h54);
    rd_chk(4'd5, "R6 empty", 32'h54);
    // R9 unmapped
    rd_chk(4'd9, "R9 unmapped", 32'hFFFF_FFFF);
    rd_chk(4'd15, "R9 unmapped", 32'hFFFF_FFFF);
    // R2 request latch and hold
    cyc(0, 0, 0, 0, 26'h0000_0A0);
    rd_chk(4'd1, "R2 sticky", 32'h0000_00A0);
    rd_chk(4'd5, "R6 lowest", 32'd5 << 2);
    // R6 write ignored
    cyc(1, 0, 4'd5, 32'h0, '0);
    rd_chk(4'd5, "R6 write ignored", 32'd5 << 2);
    // R5 unmask, steer to fast then normal
    cyc(1, 0, 4'd0, 32'h20, '0);
    cyc(1, 0, 4'd2, 32'h0, '0);
    cyc(0, 0, 0, 0, '0);
    chk("R5 fast low", {31'b0, fiq_n}, 32'd0);
    chk("R5 normal low", {31'b0, irq_n}, 32'd0);
    // R3 clear only bit 5
    cyc(1, 0, 4'd1, 32'h20, '0);
    rd_chk(4'd1, "R3 w1c", 32'h80);
    chk("R5 fast released", {31'b0, fiq_n}, 32'd1);
    // R4 same-cycle set and clear
    cyc(1, 0, 4'd1, 32'h80, 26'h80);
    rd_chk(4'd1, "R4 set wins", 32'h80);
    // R7 test load with upper bits dropped
    cyc(1, 0, 4'd3, 32'hFC00_0001, '0);
    rd_chk(4'd3, "R7 test", 32'h1);
    rd_chk(4'd1, "R7 pend", 32'h1);
    rd_chk(4'd5, "R6 bit0", 32'h0);
    cyc(1, 0, 4'd3, 32'h0200_0000, '0);
    rd_chk(4'd5, "R6 top bit", 32'd25 << 2);
    // R8 width limits
    cyc(1, 0, 4'd0, 32'hFFFF_FFFF, '0);
    rd_chk(4'd0, "R8 mode", 32'h03FF_FFFF);
    cyc(1, 0, 4'd4, 32'hDEAD_BEEF, '0);
    rd_chk(4'd4, "R8 fast", 32'hDEAD_BEEF);
    cyc(1, 0, 4'd1, 32'hFFFF_FFFF, '0);
    rd_chk(4'd5, "R6 empty again", 32'h54);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      logic [NSRC-1:0] rq;
      r  = $urandom;
      rq = NSRC'($urandom & $urandom & $urandom & $urandom);
      if (r[3:0] < 4'd3) rq = '0;
      cyc(r[4] & r[5], r[6], (r[7] ? {1'b0, r[10:8]} : r[11:8]),
          (r[12] ? $urandom : ($urandom & $urandom)), rq);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule